// File: doc/BRIEF.md
# BCD Time Alarm with Maskable Repeat Rate

This unit holds four alarm fields (seconds, minutes, hours and day of month) and compares them with the current time, which arrives as BCD bytes from a separate time counter. Bit 7 of each alarm field is a "don't care" flag. The pattern of these flags picks how often the alarm repeats: once a month, once a day, once an hour, once a minute or once a second. The comparison is made only on the cycle in which the one-second strobe is high. When the unmasked fields all match, the unit raises a one-cycle interrupt pulse, provided the interrupt enable bit is set.

Software writes the fields through a small register write port. Each alarm field write is range-checked as BCD. A value out of range is dropped, and the field keeps its old contents. A control selector holds the single interrupt enable bit.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After reset, every alarm field is 0x00, the interrupt enable is 0 and `irq_pulse` is low.
- R2: A write with `wr_sel` 0 (seconds) or 1 (minutes) reads tens from bits 6:4 and ones from bits 3:0. It is stored whole (all 8 bits) only when tens*10+ones is at most 59. Otherwise the field is unchanged.
- R3: A write with `wr_sel` 2 (hours) reads tens from bits 5:4 and ones from bits 3:0. It is stored whole only when tens*10+ones is at most 23. Otherwise the field is unchanged.
- R4: A write with `wr_sel` 3 (date) reads tens from bit 4 and ones from bits 3:0. It is stored whole only when tens*10+ones is non-zero. Otherwise the field is unchanged.
- R5: Bit 7 of each field is its mask; the mask pattern is written date,hours,minutes,seconds. The patterns select these comparisons: 0000 compares all four fields; 1000 compares hours, minutes and seconds; 1100 compares minutes and seconds; 1110 compares seconds only; 1111 compares nothing. Seconds and minutes compare bits 6:0, hours bits 5:0, and date bits 4:0.
- R6: Every mask pattern not listed in R5 compares nothing, so the alarm fires each second.
- R7: A match counts only in a cycle where `tick` is high. `irq_pulse` goes high for exactly the one cycle after that tick, and stays low when there is no tick.
- R8: A write with `wr_sel` 4 sets the interrupt enable from `wr_data` bit 0. While the enable is 0, no pulse is produced.
- R9: Writes with `wr_sel` 5, 6 or 7 have no effect on any field or on the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (0 sec, 1 min, 2 hour, 3 date, 4 control) |
| wr_data | input | 8 | Write data |
| tick | input | 1 | One-second strobe, one cycle wide |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
The block has no size parameters beyond its fixed BCD byte fields, so the bench builds it with the defaults. This keeps every write value within reach of a full sweep. For each of the four fields, all 256 byte values are written while the other fields' masks leave only that field (and the ones below it) compared. Two ticks then show whether the value was stored or dropped. All 16 mask patterns are then crossed with time inputs that each miss a single field. Further ticks cover the enable bit, the unused selectors and the values the fields take at reset.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int unsigned N_FIELDS = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned ONES_W   = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DATE = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  // number of BCD tens bits per field index (0 sec, 1 min, 2 hour, 3 date)
  function automatic int unsigned field_tens_w(int unsigned f);
    case (f)
      2:       return 2;
      3:       return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int unsigned field_max(int unsigned f);
    case (f)
      2:       return 23;
      3:       return 31;
      default: return 59;
    endcase
  endfunction

  function automatic bit field_zero_ok(int unsigned f);
    return (f != 3);
  endfunction

  function automatic logic [BYTE_W-1:0] field_cmp_mask(int unsigned f);
    return BYTE_W'((1 << (ONES_W + field_tens_w(f))) - 1);
  endfunction
endpackage

// File: rtl/bcd_field_check.sv
module bcd_field_check #(
  parameter int unsigned TENS_W  = 3,
  parameter int unsigned MAX_VAL = 59,
  parameter bit          ZERO_OK = 1'b1
) (
  input  logic [TENS_W+3:0] bits,
  output logic              ok
);
  localparam int unsigned VAL_W = 8;
  logic [VAL_W-1:0] value;

  always_comb begin
    value = VAL_W'(bits[TENS_W+3:4]) * VAL_W'(10) + VAL_W'(bits[3:0]);
    ok    = (value <= VAL_W'(MAX_VAL)) && (ZERO_OK || (value != '0));
  end
endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode import bcd_alarm_pkg::*; (
  input  logic [N_FIELDS-1:0] mask,
  output logic [N_FIELDS-1:0] cmp_en
);
  always_comb begin
    case (mask)
      4'b0000: cmp_en = 4'b1111;  // monthly
      4'b1000: cmp_en = 4'b0111;  // daily
      4'b1100: cmp_en = 4'b0011;  // hourly
      4'b1110: cmp_en = 4'b0001;  // each minute
      default: cmp_en = 4'b0000;  // each second
    endcase
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare import bcd_alarm_pkg::*; (
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] alarm,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] cur,
  input  logic [N_FIELDS-1:0]             cmp_en,
  output logic [N_FIELDS-1:0]             field_eq,
  output logic                            hit
);
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    localparam logic [BYTE_W-1:0] FMASK = field_cmp_mask(g);
    assign field_eq[g] = (((alarm[g] ^ cur[g]) & FMASK) == '0);
  end

  assign hit = &(field_eq | ~cmp_en);
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit import bcd_alarm_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tick,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_date,
  output logic              irq_pulse
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]             rst_sync_q;
  logic                               rst_q_n;
  logic [N_FIELDS-1:0][BYTE_W-1:0]    alarm_q, alarm_d, cur_w;
  logic [N_FIELDS-1:0]                wr_ok, mask_w, cmp_en, field_eq;
  logic                               ien_q, ien_d, irq_q, irq_d, hit;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[SYNC_STAGES-1];

  assign cur_w = {cur_date, cur_hour, cur_min, cur_sec};

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_chk
    localparam int unsigned TW = field_tens_w(g);
    bcd_field_check #(
      .TENS_W (TW),
      .MAX_VAL(field_max(g)),
      .ZERO_OK(field_zero_ok(g))
    ) u_chk (
      .bits(wr_data[TW+3:0]),
      .ok  (wr_ok[g])
    );
    assign mask_w[g] = alarm_q[g][BYTE_W-1];

    // R2/R3/R4: a rejected write keeps the field
    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en && (wr_sel == SEL_W'(g)) && !wr_ok[g]) |=> $stable(alarm_q[g]));
  end

  alarm_rate_decode u_dec (
    .mask  (mask_w),
    .cmp_en(cmp_en)
  );

  alarm_compare u_cmp (
    .alarm   (alarm_q),
    .cur     (cur_w),
    .cmp_en  (cmp_en),
    .field_eq(field_eq),
    .hit     (hit)
  );

  // next state
  always_comb begin
    alarm_d = alarm_q;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (wr_en && (wr_sel == SEL_W'(i)) && wr_ok[i]) alarm_d[i] = wr_data;
    end
    ien_d = ien_q;
    if (wr_en && (wr_sel == SEL_CTRL)) ien_d = wr_data[0];
    irq_d = tick & ien_q & hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      alarm_q <= '0;
      ien_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      ien_q   <= ien_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_pulse = irq_q;

  assert_pulse_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_q |-> $past(tick));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_q |-> $past(ien_q));

  assert_monthly_full_match_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_q |-> !$past((mask_w == 4'b0000) && !(&field_eq)));

  assert_no_tick_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !tick |=> !irq_q);
endmodule

// File: tb/test_bcd_alarm_unit.sv
module test_bcd_alarm_unit;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, tick;
  logic [2:0] wr_sel;
  logic [7:0] wr_data, cur_sec, cur_min, cur_hour, cur_date;
  logic       irq_pulse;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_alarm [4];
  bit         m_ien;

  always #4 clk = ~clk;

  bcd_alarm_unit i_bcd_alarm_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .irq_pulse(irq_pulse)
  );

  function automatic bit accept(int f, logic [7:0] d);
    int t, o, v;
    o = d[3:0];
    case (f)
      0, 1: t = d[6:4];
      2:    t = d[5:4];
      default: t = d[4];
    endcase
    v = t * 10 + o;
    case (f)
      0, 1: return v <= 59;
      2:    return v <= 23;
      default: return v != 0;
    endcase
  endfunction

  function automatic logic [7:0] fmask(int f);
    case (f)
      0, 1: return 8'h7F;
      2:    return 8'h3F;
      default: return 8'h1F;
    endcase
  endfunction

  function automatic bit model_hit(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
    logic [3:0] pat, use_f;
    logic [7:0] c [4];
    bit ok;
    c[0] = s; c[1] = m; c[2] = h; c[3] = d;
    pat = {m_alarm[3][7], m_alarm[2][7], m_alarm[1][7], m_alarm[0][7]};
    case (pat)
      4'b0000: use_f = 4'b1111;
      4'b1000: use_f = 4'b0111;
      4'b1100: use_f = 4'b0011;
      4'b1110: use_f = 4'b0001;
      default: use_f = 4'b0000;
    endcase
    ok = 1'b1;
    for (int i = 0; i < 4; i++)
      if (use_f[i] && ((m_alarm[i] & fmask(i)) != (c[i] & fmask(i)))) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [2:0] sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 3'd4) begin
      if (accept(int'(sel), d)) m_alarm[sel] = d;
    end else if (sel == 3'd4) begin
      m_ien = d[0];
    end
  endtask

  task automatic tick_check(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d, string req);
    bit exp;
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    tick = 1'b1;
    exp = m_ien && model_hit(s, m, h, d);
    @(negedge clk);
    tick = 1'b0;
    check(irq_pulse == exp, req, irq_pulse, exp);
    @(negedge clk);
    check(irq_pulse == 1'b0, "R7 pulse width", irq_pulse, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; tick = 1'b0;
    cur_sec = '0; cur_min = '0; cur_hour = '0; cur_date = '0;
    for (int i = 0; i < 4; i++) m_alarm[i] = 8'h00;
    m_ien = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_pulse == 1'b0, "R1 irq low in reset", irq_pulse, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq_pulse == 1'b0, "R1 irq low after reset", irq_pulse, 0);

    // R1: enable starts clear, fields start at zero (monthly, 00 everywhere)
    tick_check(8'h00, 8'h00, 8'h00, 8'h00, "R1 enable clear after reset");
    write_reg(3'd4, 8'h01);
    tick_check(8'h00, 8'h00, 8'h00, 8'h00, "R1 zero fields match zero time");
    tick_check(8'h01, 8'h00, 8'h00, 8'h00, "R1 seconds compared at reset");

    // R2/R3/R4: exhaustive write acceptance per field
    for (int f = 0; f < 4; f++) begin
      for (int j = 0; j < 4; j++) begin
        if (j > f) write_reg(3'(j), (j == 3) ? 8'h81 : 8'h80);
        else if (j < f) write_reg(3'(j), (j == 3) ? 8'h01 : 8'h00);
      end
      for (int d = 0; d < 256; d++) begin
        logic [7:0] base, c [4];
        string req;
        base = (f == 3) ? 8'h01 : 8'h00;
        req = (f < 2) ? "R2 sec/min acceptance" : (f == 2) ? "R3 hour acceptance" : "R4 date acceptance";
        write_reg(3'(f), base);
        write_reg(3'(f), 8'(d));
        for (int k = 0; k < 2; k++) begin
          for (int i = 0; i < 4; i++) c[i] = m_alarm[i] & fmask(i);
          c[f] = (k == 0) ? (8'(d) & fmask(f)) : (base & fmask(f));
          tick_check(c[0], c[1], c[2], c[3], req);
        end
      end
    end

    // R5/R6: all mask patterns against single-field misses
    for (int p = 0; p < 16; p++) begin
      write_reg(3'd0, 8'h15 | (p[0] ? 8'h80 : 8'h00));
      write_reg(3'd1, 8'h30 | (p[1] ? 8'h80 : 8'h00));
      write_reg(3'd2, 8'h12 | (p[2] ? 8'h80 : 8'h00));
      write_reg(3'd3, 8'h07 | (p[3] ? 8'h80 : 8'h00));
      tick_check(8'h15, 8'h30, 8'h12, 8'h07, "R5 exact match");
      tick_check(8'h16, 8'h30, 8'h12, 8'h07, "R5 seconds miss");
      tick_check(8'h15, 8'h31, 8'h12, 8'h07, "R5 minutes miss");
      tick_check(8'h15, 8'h30, 8'h13, 8'h07, "R5 hours miss");
      tick_check(8'h15, 8'h30, 8'h12, 8'h08, "R6 date miss");
    end

    // R7: match held without tick gives no pulse
    write_reg(3'd0, 8'h80);
    cur_sec = 8'h15; cur_min = 8'h30; cur_hour = 8'h12; cur_date = 8'h07;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(irq_pulse == 1'b0, "R7 no tick no pulse", irq_pulse, 0);
    end

    // R8: enable gating via control bit 0
    write_reg(3'd4, 8'hFE);
    tick_check(8'h15, 8'h30, 8'h12, 8'h07, "R8 disabled");
    write_reg(3'd4, 8'h01);
    tick_check(8'h15, 8'h30, 8'h12, 8'h07, "R8 re-enabled");

    // R9: unused selectors leave everything alone (monthly setup)
    write_reg(3'd0, 8'h15); write_reg(3'd1, 8'h30);
    write_reg(3'd2, 8'h12); write_reg(3'd3, 8'h07);
    for (int s = 5; s < 8; s++) write_reg(3'(s), 8'hFF);
    for (int s = 5; s < 8; s++) write_reg(3'(s), 8'h00);
    tick_check(8'h15, 8'h30, 8'h12, 8'h07, "R9 fields and enable kept");
    tick_check(8'h16, 8'h30, 8'h12, 8'h07, "R9 masks kept clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule